// File: doc/BRIEF.md
# Streaming Logic Capture Front End

This block watches a group of digital probe lines, takes a snapshot of them at a programmable rate, and streams each snapshot out as bytes over a byte-wide valid/ready port. A byte-wide command port accepts five-byte frames that start and stop the stream. The block has no capture memory. Once started, it keeps producing samples until a stop frame arrives.

The rate comes from two bytes that are latched when a start frame is accepted. A base-select byte picks one of two base clock-enable rates: a fast one nominally at 48 MHz and a slow one nominally at 30 MHz. Both are derived from the system clock with phase accumulators. A divider byte then sets how many base ticks fall between samples; the count is the divider plus one. In narrow mode each sample is one byte. In wide mode each sample is two bytes, lower probes first. The fastest settings are refused in wide mode, because they would need more than one byte per system-side slot. A refused setting raises a sticky error flag and capture does not start. When a sample comes due while the output still holds an earlier one, the new sample is dropped whole and a sticky overflow flag is raised.

Top module: `logic_capture_stream`

## Requirements
- R1: A command frame of the bytes 0x00, 0x01, 0x00, 0x00, 0x00 on consecutive accepted command bytes starts capture when the settings are legal. `running` is high in the cycle after the last byte. The divider, select and mode inputs are latched at that point.
- R2: A command frame of five 0x00 bytes stops capture. After any byte already in flight has drained, no further `out_valid` appears and `running` is low.
- R3: A frame whose second byte is neither 0x00 nor 0x01, or that has a nonzero byte in any other position, has no effect. Frame alignment restarts after every fifth command byte, whatever the content of the frame.
- R4: Select 0xEE uses the fast base and select 0xAE uses the slow base. Samples are taken every (divider+1) base ticks. With the bench parameters, fast divider d gives exactly 2*(d+1) system cycles per sample, and slow divider 4 gives 16 cycles.
- R5: In narrow mode (`wide_mode`=0) each sample is one byte, with probe n in bit n for n = 0..7.
- R6: In wide mode (`wide_mode`=1) each sample is two bytes. The first byte holds probes 0..7 and the second holds probes 8..15, each with the lowest probe in bit 0.
- R7: A start frame is refused in the following cases: the divider is 0; the select byte is neither 0xEE nor 0xAE; wide mode with select 0xEE and a divider of 2 or less; wide mode with select 0xAE and a divider of 1. A refused start sets `rate_err`, which stays set until reset, and capture does not start.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` does not change.
- R9: A sample that comes due while the output cannot take a new sample in the same cycle is dropped whole and sets `overflow`, which stays set until reset. The bytes already held are delivered in order, and later samples keep their byte order.
- R10: After reset, `out_valid`, `running`, `rate_err` and `overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_in | input | 16 | Probe levels, probe n on bit n |
| wide_mode | input | 1 | 1 selects 16-probe two-byte samples, latched at start |
| rate_div | input | 8 | Divider byte (base ticks per sample minus one), latched at start |
| base_sel | input | 8 | Base select byte: 0xEE fast, 0xAE slow, latched at start |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| out_valid | output | 1 | Sample byte available |
| out_byte | output | 8 | Sample byte |
| out_ready | input | 1 | Consumer accepts the byte in this cycle |
| running | output | 1 | Capture is active |
| rate_err | output | 1 | Sticky: a start was refused for its rate settings |
| overflow | output | 1 | Sticky: a sample was dropped |

## Verification
The bench builds the block with SYS_RATE=16, FAST_RATE=8 and SLOW_RATE=5. With these values the fast base ticks on every second cycle and the slow base ticks five times in every sixteen cycles, keeping the 8:5 ratio between the two nominal bases. The sample spacing for any divider is therefore a whole number of cycles that the bench can predict exactly, and a slow setting finishes in a few hundred cycles. Held-output and overflow cases are reached by holding `out_ready` low across several strobes, in both byte-width modes.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int DIV_W      = 8;
  localparam int CMD_W      = 8;
  localparam int FRAME_LEN  = 5;
  localparam int CMD_OP_POS = 1;

  localparam logic [7:0] SEL_FAST = 8'hEE;
  localparam logic [7:0] SEL_SLOW = 8'hAE;
  localparam logic [7:0] OP_START = 8'h01;
  localparam logic [7:0] OP_STOP  = 8'h00;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2
  } cmd_evt_e;

  // Legal rate settings for the given probe-width mode.
  function automatic logic rate_ok(input logic wide, input logic [7:0] sel,
                                   input logic [DIV_W-1:0] div);
    logic ok;
    ok = (div != '0) && ((sel == SEL_FAST) || (sel == SEL_SLOW));
    if (wide && (sel == SEL_FAST) && (div <= DIV_W'(2))) ok = 1'b0;
    if (wide && (sel == SEL_SLOW) && (div == DIV_W'(1))) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/lcs_cmd_decoder.sv
module lcs_cmd_decoder
  import lcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  output cmd_evt_e         cmd_evt
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] OP_IDX   = IDX_W'(CMD_OP_POS);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CMD_W-1:0] op_q, op_d;
  logic             junk_q, junk_d;
  logic             nz;

  always_comb begin
    idx_d   = idx_q;
    op_d    = op_q;
    junk_d  = junk_q;
    cmd_evt = CMD_NONE;
    nz      = (cmd_byte != '0);
    if (cmd_valid) begin
      if (idx_q == LAST_IDX) begin
        idx_d = '0;
        if (!(junk_q || nz)) begin
          if (op_q == OP_START)     cmd_evt = CMD_START;
          else if (op_q == OP_STOP) cmd_evt = CMD_STOP;
        end
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
      if (idx_q == '0)         junk_d = nz;
      else if (idx_q == OP_IDX) op_d  = cmd_byte;
      else                      junk_d = junk_q | nz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      op_q   <= '0;
      junk_q <= 1'b0;
    end else if (cmd_valid) begin
      idx_q  <= idx_d;
      op_q   <= op_d;
      junk_q <= junk_d;
    end
  end

  // R3: alignment index never passes the last frame position
  assert_frame_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

  // R3: after a fifth byte the next byte begins a new frame
  assert_frame_realign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && idx_q == LAST_IDX) |=> (idx_q == '0));
endmodule

// File: rtl/lcs_base_tick.sv
module lcs_base_tick #(
  parameter int SYS_RATE  = 125000,
  parameter int BASE_RATE = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int ACC_W = $clog2(SYS_RATE + BASE_RATE + 1);
  localparam logic [ACC_W-1:0] SYS_V  = ACC_W'(SYS_RATE);
  localparam logic [ACC_W-1:0] BASE_V = ACC_W'(BASE_RATE);

  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum  = acc_q + BASE_V;
    tick = (sum >= SYS_V);
    if (clr)       acc_d = '0;
    else if (tick) acc_d = sum - SYS_V;
    else           acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R4: accumulator stays within one system period
  assert_acc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < SYS_V);
endmodule

// File: rtl/lcs_rate_strobe.sv
module lcs_rate_strobe
  import lcs_pkg::*;
#(
  parameter int SYS_RATE  = 125000,
  parameter int FAST_RATE = 48000,
  parameter int SLOW_RATE = 30000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             wide_mode,
  input  logic [DIV_W-1:0] div_in,
  input  logic [7:0]       sel_in,
  output logic             running,
  output logic             strobe,
  output logic             wide_q,
  output logic             rate_err
);
  localparam int NBASE = 2;

  logic [NBASE-1:0] base_tick;
  logic             clr_base;

  generate
    for (genvar g = 0; g < NBASE; g++) begin : g_base
      localparam int RATE_G = (g == 0) ? FAST_RATE : SLOW_RATE;
      lcs_base_tick #(.SYS_RATE(SYS_RATE), .BASE_RATE(RATE_G)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_base),
        .tick (base_tick[g])
      );
    end
  endgenerate

  logic             run_q, run_d;
  logic             slow_q, slow_d;
  logic             wide_d;
  logic             err_q, err_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick;

  always_comb begin
    run_d    = run_q;
    slow_d   = slow_q;
    wide_d   = wide_q;
    err_d    = err_q;
    cnt_d    = cnt_q;
    div_d    = div_q;
    clr_base = 1'b0;
    tick     = slow_q ? base_tick[1] : base_tick[0];
    strobe   = run_q && tick && (cnt_q == '0) && !stop_evt;
    if (!run_q && start_evt) begin
      if (rate_ok(wide_mode, sel_in, div_in)) begin
        run_d    = 1'b1;
        cnt_d    = div_in;
        div_d    = div_in;
        slow_d   = (sel_in == SEL_SLOW);
        wide_d   = wide_mode;
        clr_base = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end else if (run_q && stop_evt) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      cnt_d = (cnt_q == '0) ? div_q : cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slow_q <= 1'b0;
      wide_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
    end else begin
      run_q  <= run_d;
      slow_q <= slow_d;
      wide_q <= wide_d;
      err_q  <= err_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
    end
  end

  assign running  = run_q;
  assign rate_err = err_q;

  // R7: a refused rate stays flagged
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7: a refused start leaves capture idle
  assert_err_no_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !run_q);

  // R4: a fresh run begins with the full divide count loaded
  assert_run_loads_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q == div_q));
endmodule

// File: rtl/lcs_packer.sv
module lcs_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic                    wide,
  input  logic [BYTE_W*LANES-1:0] sample,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [BYTE_W-1:0]       out_byte,
  output logic                    overflow
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

  logic [BYTE_W*LANES-1:0] smp_q, smp_d;
  logic [LANE_W-1:0]       lane_q, lane_d, last_q, last_d;
  logic                    vld_q, vld_d;
  logic                    ovf_q, ovf_d;
  logic                    xfer, free;
  logic [BYTE_W-1:0]       lane_bytes [LANES];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_bytes[g] = smp_q[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    smp_d  = smp_q;
    lane_d = lane_q;
    last_d = last_q;
    vld_d  = vld_q;
    ovf_d  = ovf_q;
    xfer   = vld_q && out_ready;
    free   = !vld_q || (xfer && (lane_q == last_q));
    if (xfer) begin
      if (lane_q == last_q) vld_d = 1'b0;
      else                  lane_d = lane_q + LANE_W'(1);
    end
    if (strobe) begin
      if (free) begin
        smp_d  = sample;
        lane_d = '0;
        last_d = wide ? TOP_LANE : '0;
        vld_d  = 1'b1;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      lane_q <= '0;
      last_q <= '0;
      vld_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      lane_q <= lane_d;
      last_q <= last_d;
      vld_q  <= vld_d;
      ovf_q  <= ovf_d;
    end
  end

  assign out_valid = vld_q;
  assign out_byte  = lane_bytes[lane_q];
  assign overflow  = ovf_q;

  // R8: a stalled byte is held unchanged
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(out_byte)));

  // R9: a dropped sample stays flagged
  assert_no_overflow_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R6: byte position never passes the last lane of the held sample
  assert_lane_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lane_q <= last_q);
endmodule

// File: rtl/logic_capture_stream.sv
module logic_capture_stream
  import lcs_pkg::*;
#(
  parameter int SYS_RATE  = 125000,
  parameter int FAST_RATE = 48000,
  parameter int SLOW_RATE = 30000,
  parameter int BYTE_W    = 8,
  parameter int LANES     = 2,
  localparam int PROBE_W  = BYTE_W * LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_in,
  input  logic               wide_mode,
  input  logic [DIV_W-1:0]   rate_div,
  input  logic [7:0]         base_sel,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_byte,
  output logic               out_valid,
  output logic [BYTE_W-1:0]  out_byte,
  input  logic               out_ready,
  output logic               running,
  output logic               rate_err,
  output logic               overflow
);
  cmd_evt_e cmd_evt;
  logic     strobe;
  logic     wide_q;

  lcs_cmd_decoder u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_byte (cmd_byte),
    .cmd_evt  (cmd_evt)
  );

  lcs_rate_strobe #(
    .SYS_RATE (SYS_RATE),
    .FAST_RATE(FAST_RATE),
    .SLOW_RATE(SLOW_RATE)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(cmd_evt == CMD_START),
    .stop_evt (cmd_evt == CMD_STOP),
    .wide_mode(wide_mode),
    .div_in   (rate_div),
    .sel_in   (base_sel),
    .running  (running),
    .strobe   (strobe),
    .wide_q   (wide_q),
    .rate_err (rate_err)
  );

  lcs_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wide     (wide_q),
    .sample   (probe_in),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_byte (out_byte),
    .overflow (overflow)
  );

  // R2: nothing new is produced once stopped and drained
  assert_idle_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !out_valid) |=> !out_valid);
endmodule

// File: tb/tb_logic_capture_stream.sv
module tb_logic_capture_stream;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] probe_in;
  logic        wide_mode;
  logic [7:0]  rate_div, base_sel, cmd_byte, out_byte;
  logic        cmd_valid, out_valid, out_ready, running, rate_err, overflow;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic_capture_stream #(.SYS_RATE(16), .FAST_RATE(8), .SLOW_RATE(5)) dut (
    .clk(clk), .rst_n(rst_n), .probe_in(probe_in), .wide_mode(wide_mode),
    .rate_div(rate_div), .base_sel(base_sel), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .out_valid(out_valid), .out_byte(out_byte),
    .out_ready(out_ready), .running(running), .rate_err(rate_err),
    .overflow(overflow)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_byte = '0; probe_in = '0;
    wide_mode = 1'b0; rate_div = 8'd3; base_sel = 8'hEE; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b0, b1, b2, b3, b4);
    logic [7:0] f [5];
    f = '{b0, b1, b2, b3, b4};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = f[i];
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte  = '0;
  endtask

  task automatic recv(output logic [7:0] b, output int t, output bit got);
    got = 1'b0; b = '0; t = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (out_valid && out_ready) begin
        b = out_byte; t = cyc; got = 1'b1;
        return;
      end
    end
  endtask

  task automatic count_valid(input int ncyc, output int n);
    n = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (out_valid) n++;
    end
  endtask

  task automatic test_reset();
    do_reset();
    chk(out_valid == 0, "R10", "out_valid after reset", out_valid, 0);
    chk(running == 0,   "R10", "running after reset", running, 0);
    chk(rate_err == 0 && overflow == 0, "R10", "flags after reset",
        {rate_err, overflow}, 0);
  endtask

  task automatic test_narrow();
    logic [7:0] b, pat;
    int t, tprev, n;
    bit got;
    do_reset();
    pat = 8'h5A; probe_in = {8'hFF, pat};
    rate_div = 8'd3; base_sel = 8'hEE; wide_mode = 1'b0;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    chk(running == 1, "R1", "running after start frame", running, 1);
    tprev = 0;
    for (int k = 0; k < 6; k++) begin
      recv(b, t, got);
      chk(got && b == pat, "R5", "narrow sample byte", b, pat);
      if (k > 0) chk(t - tprev == 8, "R4", "fast div3 spacing", t - tprev, 8);
      tprev = t;
      pat = pat ^ 8'(8'h93 + k * 8'h25);
      probe_in = {~pat, pat};
    end
    send_frame(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk(running == 0, "R2", "running after stop frame", running, 0);
    repeat (3) @(negedge clk);
    count_valid(100, n);
    chk(n == 0, "R2", "bytes after stop", n, 0);
  endtask

  task automatic test_fast_div2();
    logic [7:0] b;
    int t, tprev;
    bit got;
    do_reset();
    probe_in = 16'h00C3; rate_div = 8'd2; base_sel = 8'hEE;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    recv(b, tprev, got);
    for (int k = 0; k < 3; k++) begin
      recv(b, t, got);
      chk(got && t - tprev == 6, "R4", "fast div2 spacing", t - tprev, 6);
      tprev = t;
    end
  endtask

  task automatic test_wide();
    logic [7:0] lo, hi;
    logic [15:0] pat;
    int t0, t1, tprev;
    bit g0, g1;
    do_reset();
    pat = 16'hC01E; probe_in = pat;
    rate_div = 8'd3; base_sel = 8'hEE; wide_mode = 1'b1;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    chk(running == 1 && rate_err == 0, "R7", "wide 12MHz-class setting allowed",
        {running, rate_err}, 2);
    tprev = 0;
    for (int k = 0; k < 4; k++) begin
      recv(lo, t0, g0);
      recv(hi, t1, g1);
      chk(g0 && lo == pat[7:0],  "R6", "wide first byte probes 0-7", lo, pat[7:0]);
      chk(g1 && hi == pat[15:8], "R6", "wide second byte probes 8-15", hi, pat[15:8]);
      if (k > 0) chk(t0 - tprev == 8, "R4", "wide sample spacing", t0 - tprev, 8);
      tprev = t0;
      pat = {pat[14:0], pat[15]} ^ 16'h3A5C;
      probe_in = pat;
    end
  endtask

  task automatic test_frames();
    logic [7:0] b;
    int t;
    bit got;
    do_reset();
    probe_in = 16'h0077;
    send_frame(8'h00, 8'h02, 8'h00, 8'h00, 8'h00);
    chk(running == 0, "R3", "unknown opcode ignored", running, 0);
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h07);
    chk(running == 0, "R3", "nonzero tail byte ignored", running, 0);
    send_frame(8'h04, 8'h01, 8'h00, 8'h00, 8'h00);
    chk(running == 0, "R3", "nonzero head byte ignored", running, 0);
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    chk(running == 1, "R3", "start after ignored frames", running, 1);
    recv(b, t, got);
    chk(got && b == 8'h77, "R5", "first byte after realigned start", b, 8'h77);
    send_frame(8'h00, 8'h09, 8'h00, 8'h00, 8'h00);
    chk(running == 1, "R3", "bad frame while running ignored", running, 1);
  endtask

  task automatic refuse(input bit wide, input logic [7:0] sel, input logic [7:0] div,
                        input string what);
    int n;
    do_reset();
    wide_mode = wide; base_sel = sel; rate_div = div;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    chk(rate_err == 1 && running == 0, "R7", what, {rate_err, running}, 2);
    count_valid(60, n);
    chk(n == 0, "R7", {what, " no output"}, n, 0);
  endtask

  task automatic test_rate_err();
    refuse(1'b1, 8'hEE, 8'd1, "wide fast div1 refused");
    refuse(1'b1, 8'hEE, 8'd2, "wide fast div2 refused");
    refuse(1'b1, 8'hAE, 8'd1, "wide slow div1 refused");
    refuse(1'b0, 8'h55, 8'd3, "unknown select refused");
    refuse(1'b0, 8'hEE, 8'd0, "zero divider refused");
    rate_div = 8'd3; base_sel = 8'hEE; wide_mode = 1'b1;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    chk(running == 1 && rate_err == 1, "R7", "error sticky across legal start",
        {running, rate_err}, 3);
    do_reset();
    wide_mode = 1'b0; base_sel = 8'hEE; rate_div = 8'd1;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    chk(running == 1 && rate_err == 0, "R7", "narrow fast div1 allowed",
        {running, rate_err}, 2);
  endtask

  task automatic test_slow();
    logic [7:0] b;
    int t, tprev, n;
    bit got;
    do_reset();
    probe_in = 16'h0011; base_sel = 8'hAE; rate_div = 8'd4;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    recv(b, tprev, got);
    for (int k = 0; k < 3; k++) begin
      recv(b, t, got);
      chk(got && t - tprev == 16, "R4", "slow div4 spacing", t - tprev, 16);
      tprev = t;
    end
    do_reset();
    base_sel = 8'hAE; rate_div = 8'd1;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    repeat (20) @(negedge clk);
    count_valid(320, n);
    chk(n >= 49 && n <= 51, "R4", "slow div1 samples in 320 cycles", n, 50);
  endtask

  task automatic test_overflow();
    logic [7:0] b;
    int t;
    bit got;
    do_reset();
    out_ready = 1'b0; probe_in = 16'h00A1; rate_div = 8'd3;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 40 && !out_valid; i++) @(negedge clk);
    chk(out_valid && out_byte == 8'hA1, "R8", "first held byte", out_byte, 8'hA1);
    probe_in = 16'h00B2;
    repeat (20) @(negedge clk);
    chk(overflow == 1, "R9", "overflow after stalled strobe", overflow, 1);
    chk(out_valid && out_byte == 8'hA1, "R8", "byte held while stalled", out_byte, 8'hA1);
    out_ready = 1'b1;
    recv(b, t, got);
    chk(got && b == 8'hB2, "R9", "next sample after drop", b, 8'hB2);

    do_reset();
    out_ready = 1'b0; wide_mode = 1'b1; probe_in = 16'h4C3D; rate_div = 8'd3;
    send_frame(8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 40 && !out_valid; i++) @(negedge clk);
    probe_in = 16'h6E5F;
    repeat (20) @(negedge clk);
    chk(overflow == 1, "R9", "wide overflow flag", overflow, 1);
    chk(out_byte == 8'h3D, "R8", "wide held low byte", out_byte, 8'h3D);
    out_ready = 1'b1;
    recv(b, t, got);
    chk(got && b == 8'h4C, "R9", "wide held high byte after drop", b, 8'h4C);
    recv(b, t, got);
    chk(got && b == 8'h5F, "R9", "wide later low byte order", b, 8'h5F);
    recv(b, t, got);
    chk(got && b == 8'h6E, "R9", "wide later high byte order", b, 8'h6E);
  endtask

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    test_reset();
    test_narrow();
    test_fast_div2();
    test_wide();
    test_frames();
    test_rate_err();
    test_slow();
    test_overflow();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule